// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends words on an asynchronous serial line. A one-word holding stage, written by the system side, feeds a frame shifter. The frame shifter moves one bit per transmit tick. An internal divider derives that tick from the system clock. Because of the holding stage, software can queue the next word while the current frame is still on the line.

Two flags pace the writer. `hold_empty` shows that the holding stage can take a word. `tx_done` shows that the shifter has sent the final stop bit and is idle. A single control input, `bit9_ctl`, has two uses: in the 9-bit format it is the ninth data bit, and in the parity format it selects odd or even parity. Four frame formats are available.

When the transmit enable is removed, the frame on the line still finishes cleanly. The word waiting in the holding stage is then discarded.

Top module: `sertx_top`

## Requirements
- R1: While and after reset, `tx_line` is 1, `hold_empty` is 1 and `tx_done` is 1.
- R2: A frame is a low start bit, then data least significant bit first, then high stop level; `frame_mode` 2'b00 sends 8 data bits and one stop bit (10 bit times), and the idle line is high.
- R3: `frame_mode` 2'b01 sends 8 data bits, then a parity bit equal to the XOR of the data bits XOR `bit9_ctl` (0 gives even, 1 gives odd), then one stop bit.
- R4: `frame_mode` 2'b10 sends 8 data bits followed by two high stop bits (11 bit times).
- R5: `frame_mode` 2'b11 sends 8 data bits from `wr_data`, then `bit9_ctl` as the ninth data bit, then one stop bit.
- R6: Each bit lasts 2^(`baud_sel`+1) system clocks for codes 0 to 6 and exactly one clock for code 3'b111.
- R7: While `tx_en` is 0 a write strobe has no effect: `hold_empty` stays 1 and the line stays idle.
- R8: An accepted write makes `hold_empty` 0 from the next cycle. On the edge where the word moves into the shifter, `hold_empty` returns to 1 and `tx_done` falls to 0.
- R9: A write made while `hold_empty` is 0 is dropped and never transmitted.
- R10: `tx_done` rises one clock after the end of the last stop bit. A held word moves into the shifter only while `tx_done` is 1. `tx_done` can be 1 while `hold_empty` is 0.
- R11: Clearing `tx_en` during a frame lets that frame complete unchanged and discards any held, unsent word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Word to send |
| frame_mode | input | 2 | Frame format select |
| bit9_ctl | input | 1 | Ninth data bit, or parity polarity |
| tx_en | input | 1 | Transmit enable |
| baud_sel | input | 3 | Bit-rate code |
| tx_line | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Holding stage can take a word |
| tx_done | output | 1 | Shifter idle, last stop bit sent |

## Verification
The frame path is driven through a table of words that covers all four formats. The words are chosen so that each format produces a distinctive bit:
- odd and even data weights, with both parity polarities, so that the parity bit takes both values;
- a ninth bit of both values;
- a word of all ones and a word of all zeros.

These words separate a wrong bit order, a parity of the wrong sense and a missing second stop bit. Several bit-rate codes, including the undivided one, show whether the bit length follows the code or is off by one clock. Back-to-back writes test the holding stage:
- a queued word must follow its predecessor exactly one clock after `tx_done`;
- a third write into a full holding stage must never appear on the line.

Removing the enable mid-frame must neither cut the frame short nor let the waiting word through.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    FR_8N1 = 2'b00,
    FR_8P1 = 2'b01,
    FR_8N2 = 2'b10,
    FR_9B  = 2'b11
  } frame_t;
endpackage

// File: rtl/sertx_baud_div.sv
module sertx_baud_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_n, limit;
  logic [SEL_W-1:0] shamt;
  logic [CNT_W:0]   span;

  // The all-ones code wraps the shift amount to zero, which gives a span of one clock.
  always_comb begin
    shamt = sel + SEL_W'(1);
    span  = (CNT_W+1)'(1) << shamt;
    limit = CNT_W'(span - (CNT_W+1)'(1));
  end

  always_comb begin
    tick  = run && (cnt_q == limit);
    cnt_n = cnt_q;
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              sh_idle,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              move
);
  logic              full_q, full_n;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  always_comb begin
    accept = tx_en && wr_stb && !full_q;
    move   = tx_en && full_q && sh_idle;
    full_n = full_q;
    if (!tx_en)      full_n = 1'b0;
    else if (accept) full_n = 1'b1;
    else if (move)   full_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (accept) data_q <= wr_data;
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [1:0]        ld_mode,
  input  logic              ld_b9,
  input  logic              tick,
  output logic              busy,
  output logic              line
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int LEFT_W  = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [LEFT_W-1:0]  left_q, left_n;
  logic               busy_q, busy_n;
  logic               extra;
  frame_t             mode;

  always_comb begin
    mode = frame_t'(ld_mode);
    case (mode)
      FR_8P1:  extra = (^ld_data) ^ ld_b9;
      FR_9B:   extra = ld_b9;
      default: extra = 1'b1;
    endcase
  end

  always_comb begin
    sh_n   = sh_q;
    left_n = left_q;
    busy_n = busy_q;
    if (load) begin
      sh_n   = {1'b1, extra, ld_data, 1'b0};
      left_n = (mode == FR_8N1) ? LEFT_W'(FRAME_W - 1) : LEFT_W'(FRAME_W);
      busy_n = 1'b1;
    end else if (busy_q && tick) begin
      sh_n   = {1'b1, sh_q[FRAME_W-1:1]};
      left_n = left_q - LEFT_W'(1);
      if (left_q == LEFT_W'(1)) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      left_q <= left_n;
      busy_q <= busy_n;
    end
  end

  assign busy = busy_q;
  assign line = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        frame_mode,
  input  logic              bit9_ctl,
  input  logic              tx_en,
  input  logic [SEL_W-1:0]  baud_sel,
  output logic              tx_line,
  output logic              hold_empty,
  output logic              tx_done
);
  logic              full, move, busy, tick;
  logic [DATA_W-1:0] held;

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .tx_en   (tx_en),
    .sh_idle (!busy),
    .full    (full),
    .data    (held),
    .move    (move)
  );

  sertx_baud_div #(.SEL_W(SEL_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .sel   (baud_sel),
    .tick  (tick)
  );

  sertx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (move),
    .ld_data (held),
    .ld_mode (frame_mode),
    .ld_b9   (bit9_ctl),
    .tick    (tick),
    .busy    (busy),
    .line    (tx_line)
  );

  assign hold_empty = !full;
  assign tx_done    = !busy;
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic tx_en,
  input logic tx_line,
  input logic hold_empty,
  input logic tx_done
);
  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> tx_line);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_done) |-> !tx_line);

  // R2
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(tx_line));

  // R7
  wr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && wr_stb && hold_empty) |=> hold_empty);

  // R8
  fill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_empty) |-> $past(wr_stb && tx_en));

  // R8
  move_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_done) |-> $rose(hold_empty));

  // R10
  held_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_empty && !tx_done && tx_en) |=> !hold_empty);
endmodule

bind sertx_top sertx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_stb     (wr_stb),
  .tx_en      (tx_en),
  .tx_line    (tx_line),
  .hold_empty (hold_empty),
  .tx_done    (tx_done)
);

// File: tb/sertx_top_test.sv
module sertx_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] frame_mode = '0;
  logic       bit9_ctl = 1'b0;
  logic       tx_en = 1'b0;
  logic [2:0] baud_sel = 3'b111;
  logic       tx_line, hold_empty, tx_done;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sertx_top uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .frame_mode(frame_mode), .bit9_ctl(bit9_ctl), .tx_en(tx_en),
    .baud_sel(baud_sel), .tx_line(tx_line), .hold_empty(hold_empty),
    .tx_done(tx_done)
  );

  // Vector fields: {data[13:6], ninth/polarity[5], mode[4:3], baud[2:0]}
  localparam logic [13:0] VECS [0:7] = '{
    {8'hA5, 1'b0, 2'b00, 3'b111},
    {8'h3C, 1'b0, 2'b01, 3'b000},
    {8'h07, 1'b1, 2'b01, 3'b111},
    {8'h01, 1'b0, 2'b01, 3'b001},
    {8'h80, 1'b0, 2'b10, 3'b010},
    {8'hFF, 1'b0, 2'b11, 3'b111},
    {8'h12, 1'b1, 2'b11, 3'b000},
    {8'h00, 1'b0, 2'b00, 3'b011}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] build(input logic [7:0] d, input logic b9, input logic [1:0] m);
    logic extra;
    case (m)
      2'b01:   extra = (^d) ^ b9;
      2'b11:   extra = b9;
      default: extra = 1'b1;
    endcase
    return {1'b1, extra, d, 1'b0};
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // Starts at the first negedge of the start bit; ends one negedge after the frame's last clock.
  task automatic check_frame(input logic [10:0] exp, input int len, input int d, input string tag);
    int cur = 0;
    bit bad = 0;
    int act_bits = 0;
    for (int k = 0; k < len; k++) begin
      int tgt = k*d + d/2;
      repeat (tgt - cur) @(negedge clk);
      cur = tgt;
      act_bits[k] = tx_line;
      if (tx_line !== exp[k]) bad = 1;
    end
    chk(!bad, tag, act_bits, int'(exp) & ((1 << len) - 1));
    repeat (len*d - 1 - cur) @(negedge clk);
    chk(tx_done == 1'b0, "R10", tx_done, 0);
    @(negedge clk);
    chk(tx_done == 1'b1, "R6", tx_done, 1);
  endtask

  task automatic write_word(input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_stb  = 1'b1;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic run_vec(input logic [13:0] v);
    logic [7:0] d;
    logic       b9;
    logic [1:0] m;
    logic [2:0] b;
    int         dv, len;
    {d, b9, m, b} = v;
    dv  = (b == 3'b111) ? 1 : (1 << (b + 1));
    len = (m == 2'b00) ? 10 : 11;
    @(negedge clk);
    frame_mode = m;
    bit9_ctl   = b9;
    baud_sel   = b;
    write_word(d);
    chk(hold_empty == 1'b0, "R8", hold_empty, 0);
    chk(tx_done == 1'b1, "R10", tx_done, 1);
    @(negedge clk);
    chk(hold_empty == 1'b1 && tx_done == 1'b0, "R8", {hold_empty, tx_done}, 2'b10);
    check_frame(build(d, b9, m), len, dv, mode_tag(m));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(tx_line == 1'b1, "R1", tx_line, 1);
    chk(hold_empty == 1'b1 && tx_done == 1'b1, "R1", {hold_empty, tx_done}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_line == 1'b1 && hold_empty == 1'b1 && tx_done == 1'b1, "R1",
        {tx_line, hold_empty, tx_done}, 3'b111);

    // R7: writes while disabled are ignored
    begin
      bit moved = 0;
      write_word(8'h55);
      chk(hold_empty == 1'b1, "R7", hold_empty, 1);
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (tx_line !== 1'b1 || tx_done !== 1'b1) moved = 1;
      end
      chk(!moved, "R7", moved, 0);
    end

    tx_en = 1'b1;
    foreach (VECS[i]) run_vec(VECS[i]);

    // R9 and R10: queued word follows, overfull write dropped
    @(negedge clk);
    frame_mode = 2'b00;
    bit9_ctl   = 1'b0;
    baud_sel   = 3'b000;
    write_word(8'hC3);
    @(negedge clk);
    fork
      check_frame(build(8'hC3, 1'b0, 2'b00), 10, 2, "R2");
      begin
        write_word(8'h69);
        chk(hold_empty == 1'b0, "R8", hold_empty, 0);
        write_word(8'hF0);
        chk(hold_empty == 1'b0, "R9", hold_empty, 0);
      end
    join
    chk(hold_empty == 1'b0, "R10", hold_empty, 0);
    @(negedge clk);
    chk(hold_empty == 1'b1 && tx_line == 1'b0, "R10", {hold_empty, tx_line}, 2'b10);
    check_frame(build(8'h69, 1'b0, 2'b00), 10, 2, "R9");
    begin
      bit moved = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (tx_line !== 1'b1) moved = 1;
      end
      chk(!moved, "R9", moved, 0);
    end

    // R11: disable mid-frame
    write_word(8'h9A);
    @(negedge clk);
    fork
      check_frame(build(8'h9A, 1'b0, 2'b00), 10, 2, "R11");
      begin
        write_word(8'h44);
        repeat (3) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(hold_empty == 1'b1, "R11", hold_empty, 1);
      end
    join
    begin
      bit moved = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (tx_line !== 1'b1) moved = 1;
      end
      tx_en = 1'b1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (tx_line !== 1'b1) moved = 1;
      end
      chk(!moved && hold_empty == 1'b1, "R11", moved, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule